// File: doc/BRIEF.md
# SPI Serial Memory Slave with Block Write Protection

This block is the serial-bus side of a byte-addressed nonvolatile memory. The storage is modelled here as an on-chip register file. A host drives a four-wire SPI link of chip select, serial clock, data in and data out, and issues byte commands. The commands read the array, load a page of write data, set or clear a write-enable latch, and read or write a status register. The block samples all pins with its own system clock. It therefore accepts both SPI modes in which sampling happens on the rising clock edge (clock idling low and clock idling high).

A write command collects up to one page of bytes in a local buffer. When chip select rises it starts a self-timed busy phase, during which the buffered bytes are copied into the array. Two status bits pick how much of the top of the array is write protected. A protect-enable status bit together with a low level on the write-protect pin freezes the status register. The busy time is a parameter, so a real programming time or a short simulation time can be chosen.

Top module: `eep_spi_slave`

## Requirements
- R1: Each bit on `si_i` is taken on a rising edge of `sck_i`, most significant bit first. Transfers work both with `sck_i` idling low and with `sck_i` idling high while `cs_n_i` is low.
- R2: `so_o` moves to its next bit only on a falling edge of `sck_i`. `so_oe_o` is 1 only while a transfer is open and falls within three clock cycles of `cs_n_i` going high.
- R3: After reset, bits clocked in are ignored until `cs_n_i` has been seen going from high to low.
- R4: The command byte is the first byte of each transfer. Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns the status byte, repeated for as long as clocks continue. The status byte is bit 0 busy, bit 1 write-enable latch, bits 3:2 protect level, bits 5:4 two spare setting bits, bit 6 always 0 and bit 7 protect-enable. All bits are 0 after reset.
- R5: Opcode 0x03 is followed by a 16-bit address, high byte first. Address bits above the array size are ignored. Data then streams out from that address, incrementing, and wraps from the last byte to byte 0.
- R6: Opcode 0x02 is followed by a 16-bit address and data bytes. Data bytes fill the page of `PAGE_BYTES` bytes that holds the address, wrapping inside that page. Only bytes actually sent are changed, once chip select rises.
- R7: A write (0x02) or status write (0x01) issued while the write-enable latch is 0 has no effect.
- R8: An accepted write or status write starts a busy phase of `BUSY_CYCLES` clocks. During it, status bit 0 reads 1 and every command other than 0x05 is ignored. At its end, the write-enable latch is cleared.
- R9: Protect level 0 guards nothing, 1 guards the top quarter of the array, 2 guards the top half and 3 guards all of it. A write aimed at a guarded page is dropped, with no busy phase and the latch left set.
- R10: While `wp_n_i` is low and protect-enable is 1, a status write is dropped, with no busy phase and the latch left set.
- R11: A write or status write whose chip select rises when the bit count is not a multiple of 8 is dropped, with no busy phase and the latch left set.
- R12: A status write (0x01 plus one byte) sets bits 7, 5:4 and 3:2 from that byte. Bits 6, 1 and 0 of the byte are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples every bus pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bus clock |
| cs_n_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data from host |
| wp_n_i | input | 1 | Write-protect pin, active low |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for `so_o`; the pad is high impedance when 0 |

## Verification
The hardest states to reach from the pins are commands that arrive inside the busy window and transfers cut short in the middle of a byte. The bench shortens the busy time so that a whole status poll and a rejected status write both fit inside one programming phase. It then checks that the status read shows busy and that the protect level stayed put. It also ends a write transfer three bits into a byte and confirms that no busy phase follows and the array byte is unchanged. Every address is checked against a model in the bench: the array is filled first, read back once with address wrap, and then probed after each protect level and lock combination.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OP, ST_ADH, ST_ADL, ST_WDAT, ST_RDAT, ST_RDSR, ST_WSR, ST_DROP
  } cmd_st_t;

  // Guard decision from protect level and the top two address bits.
  function automatic logic blk_prot(input logic [1:0] lvl, input logic [1:0] qtr);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return qtr == 2'd3;
      2'd2:    return qtr[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/eep_sync.sv
`timescale 1ns/1ps
module eep_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eep_mem.sv
`timescale 1ns/1ps
module eep_mem #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_ctrl.sv
`timescale 1ns/1ps
module eep_ctrl import eep_pkg::*; #(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000000,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int PW  = $clog2(PAGE_BYTES),
  localparam int BCW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_in,
  input  logic          out_stb,
  input  logic          frm_open,
  input  logic          frm_close,
  input  logic          wp_n_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          so,
  output logic          so_en
);
  cmd_st_t          st_q, st_d;
  logic             act_q, act_d, rd_q, rd_d, any_q, any_d, srh_q, srh_d;
  logic [2:0]       bc_q, bc_d;
  logic [6:0]       sh_q, sh_d;
  logic [7:0]       ahi_q, ahi_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [4:0]       srn_q, srn_d;
  logic             wel_q, wel_d, busy_q, busy_d, barr_q, barr_d, so_q, so_d;
  logic             wpen_q, wpen_d;
  logic [1:0]       cfg_q, cfg_d, bp_q, bp_d;
  logic [BCW-1:0]   bcnt_q, bcnt_d;
  logic [AW-PW-1:0] cpg_q, cpg_d;
  logic [7:0]       pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask_q;
  logic             pwr, pclr;

  logic       byte_stb, locked, wr_go, sr_go, busy_end;
  logic [7:0] byte_v, status;
  logic [PW-1:0] cidx;

  assign byte_stb = bit_stb & act_q & (bc_q == 3'd7);
  assign byte_v   = {sh_q, bit_in};
  assign locked   = ~wp_n_s & wpen_q;
  assign wr_go    = frm_close & act_q & (st_q == ST_WDAT) & any_q & (bc_q == 3'd0)
                  & ~blk_prot(bp_q, addr_q[AW-1 -: 2]);
  assign sr_go    = frm_close & act_q & srh_q & (bc_q == 3'd0) & ~locked;
  assign status   = {wpen_q, 1'b0, cfg_q, bp_q, wel_q, busy_q};
  assign busy_end = busy_q & (bcnt_q == BCW'(BUSY_CYCLES - 1));
  assign cidx     = bcnt_q[PW-1:0];

  assign mem_we    = busy_q & barr_q & (bcnt_q < BCW'(PAGE_BYTES)) & pmask_q[cidx];
  assign mem_waddr = {cpg_q, cidx};
  assign mem_wdata = pbuf[cidx];
  assign mem_raddr = addr_q;
  assign so        = so_q;
  assign so_en     = act_q;

  always_comb begin
    st_d = st_q;   act_d = act_q; rd_d = rd_q;   any_d = any_q; srh_d = srh_q;
    bc_d = bc_q;   sh_d = sh_q;   ahi_d = ahi_q; addr_d = addr_q; srn_d = srn_q;
    wel_d = wel_q; busy_d = busy_q; barr_d = barr_q; so_d = so_q;
    wpen_d = wpen_q; cfg_d = cfg_q; bp_d = bp_q; bcnt_d = bcnt_q; cpg_d = cpg_q;
    pwr = 1'b0;    pclr = 1'b0;

    if (frm_open) begin
      act_d = 1'b1; st_d = ST_OP; bc_d = 3'd0; srh_d = 1'b0; any_d = 1'b0;
    end else if (frm_close) begin
      act_d = 1'b0; st_d = ST_OP;
    end else if (bit_stb && act_q) begin
      bc_d = bc_q + 3'd1;
      sh_d = {sh_q[5:0], bit_in};
      if (bc_q == 3'd7) begin
        case (st_q)
          ST_OP: begin
            if (busy_q) st_d = (byte_v == OP_RDSR) ? ST_RDSR : ST_DROP;
            else begin
              st_d = ST_DROP;
              case (byte_v)
                OP_WREN:  wel_d = 1'b1;
                OP_WRDI:  wel_d = 1'b0;
                OP_RDSR:  st_d = ST_RDSR;
                OP_WRSR:  if (wel_q) st_d = ST_WSR;
                OP_READ:  begin rd_d = 1'b1; st_d = ST_ADH; end
                OP_WRITE: if (wel_q) begin rd_d = 1'b0; st_d = ST_ADH; pclr = 1'b1; end
                default:  st_d = ST_DROP;
              endcase
            end
          end
          ST_ADH:  begin ahi_d = byte_v; st_d = ST_ADL; end
          ST_ADL:  begin
            addr_d = AW'({ahi_q, byte_v});
            st_d   = rd_q ? ST_RDAT : ST_WDAT;
          end
          ST_WDAT: begin
            pwr = 1'b1; any_d = 1'b1;
            addr_d = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
          end
          ST_RDAT: addr_d = addr_q + AW'(1);
          ST_WSR:  begin srn_d = {byte_v[7], byte_v[5:2]}; srh_d = 1'b1; st_d = ST_DROP; end
          default: st_d = st_q;
        endcase
      end
    end

    if (out_stb && act_q) begin
      if (st_q == ST_RDAT)      so_d = mem_rdata[~bc_q];
      else if (st_q == ST_RDSR) so_d = status[~bc_q];
      else                      so_d = 1'b0;
    end

    if (wr_go) begin
      busy_d = 1'b1; barr_d = 1'b1; bcnt_d = '0; cpg_d = addr_q[AW-1:PW];
    end else if (sr_go) begin
      busy_d = 1'b1; barr_d = 1'b0; bcnt_d = '0;
      wpen_d = srn_q[4]; cfg_d = srn_q[3:2]; bp_d = srn_q[1:0];
    end else if (busy_q) begin
      if (busy_end) begin busy_d = 1'b0; wel_d = 1'b0; end
      else          bcnt_d = bcnt_q + BCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OP; act_q <= 1'b0; rd_q <= 1'b0; any_q <= 1'b0; srh_q <= 1'b0;
      bc_q <= '0; sh_q <= '0; ahi_q <= '0; addr_q <= '0; srn_q <= '0;
      wel_q <= 1'b0; busy_q <= 1'b0; barr_q <= 1'b0; so_q <= 1'b0;
      wpen_q <= 1'b0; cfg_q <= '0; bp_q <= '0; bcnt_q <= '0; cpg_q <= '0;
    end else begin
      st_q <= st_d; act_q <= act_d; rd_q <= rd_d; any_q <= any_d; srh_q <= srh_d;
      bc_q <= bc_d; sh_q <= sh_d; ahi_q <= ahi_d; addr_q <= addr_d; srn_q <= srn_d;
      wel_q <= wel_d; busy_q <= busy_d; barr_q <= barr_d; so_q <= so_d;
      wpen_q <= wpen_d; cfg_q <= cfg_d; bp_q <= bp_d; bcnt_q <= bcnt_d; cpg_q <= cpg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pwr) pbuf[addr_q[PW-1:0]] <= byte_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pmask_q <= '0;
    else if (pclr) pmask_q <= '0;
    else if (pwr)  pmask_q[addr_q[PW-1:0]] <= 1'b1;
  end

  // R9: the commit stage never writes into a guarded quarter.
  assert_commit_unguarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !blk_prot(bp_q, mem_waddr[AW-1 -: 2]));

  // R7: a busy phase only starts when the write-enable latch was set.
  assert_busy_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));

  // R8: status settings hold still for the whole busy phase.
  assert_busy_freezes_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(bp_q) && $stable(wpen_q) && $stable(cfg_q)));

  // R10: while the pin lock is active, status settings do not move.
  assert_lock_holds_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> ($stable(bp_q) && $stable(wpen_q) && $stable(cfg_q)));
endmodule

// File: rtl/eep_spi_slave.sv
`timescale 1ns/1ps
module eep_spi_slave import eep_pkg::*; #(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  input  logic wp_n_i,
  output logic so_o,
  output logic so_oe_o
);
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  // Pin order: {wp_n, si, cs_n, sck}. CS resets low so that a real
  // high-to-low transition is needed before a transfer opens.
  logic [3:0] pin_s;
  logic [1:0] hist_q;

  eep_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({wp_n_i, si_i, cs_n_i, sck_i}), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) hist_q <= 2'b00;
    else          hist_q <= pin_s[1:0];
  end

  logic bit_stb, out_stb, frm_open, frm_close;
  assign bit_stb   =  pin_s[0] & ~hist_q[0];
  assign out_stb   = ~pin_s[0] &  hist_q[0];
  assign frm_open  = ~pin_s[1] &  hist_q[1];
  assign frm_close =  pin_s[1] & ~hist_q[1];

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  eep_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .bit_stb(bit_stb), .bit_in(pin_s[2]), .out_stb(out_stb),
    .frm_open(frm_open), .frm_close(frm_close), .wp_n_s(pin_s[3]),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .so(so_o), .so_en(so_oe_o)
  );

  eep_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  // R2: three clocks of chip select high leave the output released.
  assert_so_released_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !so_oe_o);
endmodule

// File: tb/tb_eep_spi_slave.sv
`timescale 1ns/1ps
module tb_eep_spi_slave;
  localparam int MEM  = 256;
  localparam int PAGE = 32;
  localparam int BUSY = 1000;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  int   n_run = 0, n_fail = 0;
  bit   mode3 = 1'b0;
  logic [7:0] model [MEM];
  logic [7:0] r, s;

  always #2.5 clk = ~clk;

  eep_spi_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .wp_n_i(wp_n),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic o);
    if (mode3) begin
      sck = 1'b0; si = b; tick(H); o = so; sck = 1'b1; tick(H);
    end else begin
      si = b; tick(H); o = so; sck = 1'b1; tick(H); sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], o);
      rx = {rx[6:0], o};
    end
  endtask

  task automatic cs_on();
    sck = mode3; tick(H); cs_n = 1'b0; tick(H);
  endtask

  task automatic cs_off();
    tick(H); cs_n = 1'b1; tick(2*H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_on(); xfer(op, d); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h05, d); xfer(8'h00, v); cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h01, d); xfer(v, d); cs_off();
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    v = 8'h01;
    for (int k = 0; k < 40; k++) begin
      rdsr(v);
      if (!v[0]) break;
    end
    chk("R8 busy ends", int'(v[0]), 0);
  endtask

  task automatic do_write(input int a, input int n, input int seed, input bit lands);
    logic [7:0] d;
    int ad;
    cs_on(); xfer(8'h02, d); xfer(8'hA5, d); xfer(8'(a), d);
    for (int i = 0; i < n; i++) begin
      ad = (a & ~(PAGE-1)) | ((a + i) & (PAGE-1));
      xfer(8'(seed + 3*i), d);
      if (lands) model[ad] = 8'(seed + 3*i);
    end
    cs_off();
  endtask

  task automatic read_chk(input int a, input int n, input string req);
    logic [7:0] d;
    cs_on(); xfer(8'h03, d); xfer(8'h5A, d); xfer(8'(a), d);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      chk(req, int'(d), int'(model[(a + i) % MEM]));
    end
    cs_off();
  endtask

  function automatic bit guarded(input int lvl, input int q);
    return (lvl == 3) || (lvl == 2 && q >= 2) || (lvl == 1 && q == 3);
  endfunction

  initial begin
    tick(int'(190000));
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d0, d1;
    // R3: chip select already low at reset, bits clocked without a falling edge.
    tick(10); rst_n = 1'b1; tick(10);
    xfer(8'h06, d0);
    tick(H); cs_n = 1'b1; tick(2*H);
    chk("R2 released after reset", int'(so_oe), 0);
    rdsr(s); chk("R3 no command before CS fall", int'(s), 8'h00);

    // R4 and R2
    cmd1(8'h06); rdsr(s); chk("R4 set latch", int'(s), 8'h02);
    cmd1(8'h04); rdsr(s); chk("R4 clear latch", int'(s), 8'h00);
    cmd1(8'h06);
    cs_on(); chk("R2 driven in transfer", int'(so_oe), 1);
    xfer(8'h05, d0); xfer(8'h00, d0); xfer(8'h00, d1); cs_off();
    chk("R4 status repeat 1", int'(d0), 8'h02);
    chk("R4 status repeat 2", int'(d1), 8'h02);
    chk("R2 released after transfer", int'(so_oe), 0);
    cmd1(8'h04);

    // Fill the array page by page (R6).
    for (int p = 0; p < MEM/PAGE; p++) begin
      cmd1(8'h06); do_write(p*PAGE, PAGE, p*41 + 7, 1'b1);
      if (p == 0) begin
        rdsr(s); chk("R8 busy shows", int'(s), 8'h03);
        wrsr(8'h0C);
        rdsr(s); chk("R8 command ignored while busy", int'(s), 8'h03);
      end
      wait_idle();
      if (p == 0) begin rdsr(s); chk("R8 latch cleared at end", int'(s), 8'h00); end
    end

    // R5 and R1: full read with wrap, in the idle-high clock mode.
    mode3 = 1'b1;
    read_chk(8'hF0, MEM + 4, "R5 R1 read wrap");
    cmd1(8'h06); do_write(8'h80, 3, 8'h90, 1'b1); wait_idle();
    read_chk(8'h7F, 5, "R1 idle-high write");
    mode3 = 1'b0;

    // R6: page wrap.
    cmd1(8'h06); do_write(8'h2E, 20, 8'h11, 1'b1); wait_idle();
    read_chk(8'h20, PAGE, "R6 page wrap");

    // R7: no latch, write ignored.
    do_write(8'h40, 1, 8'hEE, 1'b0);
    rdsr(s); chk("R7 no busy without latch", int'(s), 8'h00);
    read_chk(8'h40, 1, "R7 data kept");

    // R9: every protect level against every quarter.
    for (int lvl = 1; lvl < 4; lvl++) begin
      cmd1(8'h06); wrsr(8'(lvl << 2)); wait_idle();
      rdsr(s); chk("R12 level stored", int'(s), lvl << 2);
      for (int q = 0; q < 4; q++) begin
        cmd1(8'h06);
        do_write(q*(MEM/4) + 5, 1, lvl*16 + q, !guarded(lvl, q));
        if (guarded(lvl, q)) begin
          rdsr(s); chk("R9 guarded write dropped", int'(s), (lvl << 2) | 2);
          cmd1(8'h04);
        end else wait_idle();
        read_chk(q*(MEM/4) + 5, 1, "R9 quarter content");
      end
    end
    cmd1(8'h06); wrsr(8'h00); wait_idle();

    // R10: pin lock.
    cmd1(8'h06); wrsr(8'h80); wait_idle();
    wp_n = 1'b0; tick(H);
    cmd1(8'h06); wrsr(8'h0C);
    rdsr(s); chk("R10 locked status write dropped", int'(s), 8'h82);
    wp_n = 1'b1; tick(H);
    wrsr(8'h00); wait_idle();
    rdsr(s); chk("R10 unlocked status write", int'(s), 8'h00);

    // R12: stored bits.
    cmd1(8'h06); wrsr(8'hF3); wait_idle();
    rdsr(s); chk("R12 stored bits", int'(s), 8'hB0);
    cmd1(8'h06); wrsr(8'h00); wait_idle();

    // R11: chip select rises three bits into a byte.
    cmd1(8'h06);
    cs_on(); xfer(8'h02, d0); xfer(8'h00, d0); xfer(8'h10, d0); xfer(8'h77, d0);
    xbit(1'b1, d0[0]); xbit(1'b0, d0[0]); xbit(1'b1, d0[0]); cs_off();
    rdsr(s); chk("R11 partial write dropped", int'(s), 8'h02);
    read_chk(8'h10, 1, "R11 data kept");
    cs_on(); xfer(8'h01, d0); xfer(8'h0C, d0); xbit(1'b1, d0[0]); cs_off();
    rdsr(s); chk("R11 partial status write dropped", int'(s), 8'h02);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule